// File: doc/BRIEF.md
# Prioritized Restart Interrupt Arbiter

This block sits beside an 8-bit CPU core and decides, at each instruction boundary, which pending interrupt the core takes. It watches five request lines: a non-maskable request, three restart requests (A, B, C) that each go to a fixed address, and one vectored request whose target comes from an acknowledge cycle. Each request line is edge-detected into a pending bit. A 4-bit mask register sits at a fixed I/O port. It enables or disables each maskable source, and writes to that port are kept off the external I/O bus.

When the core pulses the boundary strobe, the block picks at most one qualified source. It then emits a one-cycle accept pulse with the source id and the 16-bit jump target, a one-cycle leave-halt pulse, and a push request for the current PC. The push request stays high until the core acknowledges the stack write. The block also owns the two interrupt enable flip-flops. The core sets them with an enable pulse and clears them with a disable pulse. Accepting a source updates them as the requirements below state.

Top module: `irq_restart_arbiter`

## Requirements
- R1: An I/O write whose low address byte equals 0xBB loads the mask register from the low data nibble and keeps `io_fwd_wr_o` low. Any other I/O write raises `io_fwd_wr_o` in the same cycle.
- R2: The mask register bits map to sources as follows: bit 3 enables restart A, bit 2 restart B, bit 1 restart C and bit 0 the vectored request. A source whose bit is clear is never accepted.
- R3: A maskable source is accepted only when its pending bit is set, its mask bit is set and IFF1 is set.
- R4: At most one source is accepted per boundary strobe. The priority order is non-maskable first, then restart A, restart B, restart C, and the vectored request last.
- R5: The accepted target and source id (`take_src_o`) are: non-maskable 0x0066, id 1; restart A 0x003C, id 2; restart B 0x0034, id 3; restart C 0x002C, id 4; vectored `ack_vector_i`, id 5. The id reads 0 when nothing is accepted.
- R6: Accepting a maskable source clears IFF1 and IFF2 and clears that source's pending bit only.
- R7: The non-maskable request is serviced whatever IFF1 holds. Accepting it clears IFF1, leaves IFF2 unchanged and clears its own pending bit.
- R8: A pending bit is set by a rising edge of its request line and stays set until that source is accepted. A request line held high does not set the bit again.
- R9: `take_o` and `leave_halt_o` are high for exactly the one cycle after the accepting strobe edge. `push_req_o` rises with them and stays high until `push_ack_i`. No source is accepted while `push_req_o` is high.
- R10: Reset clears the mask register, IFF1, IFF2, all pending bits and all outputs.
- R11: `ei_i` sets both IFF1 and IFF2, and `di_i` clears both. An accept in the same cycle takes precedence over either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr_i | input | 1 | Core I/O write strobe |
| io_addr_lo_i | input | 8 | Low byte of the I/O write address |
| io_wdata_lo_i | input | 4 | Low nibble of the I/O write data |
| io_fwd_wr_o | output | 1 | I/O write allowed onto the external bus |
| nmi_req_i | input | 1 | Non-maskable request line |
| rsta_req_i | input | 1 | Restart A request line |
| rstb_req_i | input | 1 | Restart B request line |
| rstc_req_i | input | 1 | Restart C request line |
| vec_req_i | input | 1 | Vectored request line |
| ack_vector_i | input | 16 | Target returned by the acknowledge cycle |
| ei_i | input | 1 | Enable-interrupts pulse |
| di_i | input | 1 | Disable-interrupts pulse |
| boundary_i | input | 1 | Instruction boundary strobe |
| push_ack_i | input | 1 | Stack write of the PC completed |
| take_o | output | 1 | Accept pulse |
| take_src_o | output | 3 | Accepted source id |
| take_target_o | output | 16 | Jump target of the accepted source |
| leave_halt_o | output | 1 | Exit-halt pulse |
| push_req_o | output | 1 | Request to push the current PC |
| iff1_o | output | 1 | Interrupt enable flip-flop 1 |
| iff2_o | output | 1 | Interrupt enable flip-flop 2 |

## Verification
The embedded properties check these rules on every cycle:
- The grant vector stays one-hot or empty.
- No maskable grant appears without IFF1.
- Accept pulses last a single cycle and always carry a push request.
- The enable flip-flops change as R6 and R7 require after each accept.
- Pending bits never drop without their clear.
- The mask register loads on its port write.

Other properties need whole sequences, so only the bench scenarios can show them:
- The full priority ladder as a set of simultaneous requests drains.
- The value of each fixed target.
- The fact that a held request line does not re-arm.
- Blocking while a push is outstanding.
- The mask register returning to zero after reset.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam int N_MASKABLE = 4;
  localparam int N_SRC      = N_MASKABLE + 1;
  localparam int NMI_IDX    = N_MASKABLE;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_NMI  = 3'd1,
    SRC_RSTA = 3'd2,
    SRC_RSTB = 3'd3,
    SRC_RSTC = 3'd4,
    SRC_VEC  = 3'd5
  } irq_src_e;

  // grant bit layout: [4]=NMI, [3]=A, [2]=B, [1]=C, [0]=vectored
  function automatic irq_src_e grant_to_src(input logic [N_SRC-1:0] g);
    irq_src_e s;
    s = SRC_NONE;
    if (g[4])      s = SRC_NMI;
    else if (g[3]) s = SRC_RSTA;
    else if (g[2]) s = SRC_RSTB;
    else if (g[1]) s = SRC_RSTC;
    else if (g[0]) s = SRC_VEC;
    return s;
  endfunction

  function automatic logic [15:0] src_target(input irq_src_e s, input logic [15:0] vec);
    logic [15:0] t;
    case (s)
      SRC_NMI:  t = 16'h0066;
      SRC_RSTA: t = 16'h003C;
      SRC_RSTB: t = 16'h0034;
      SRC_RSTC: t = 16'h002C;
      SRC_VEC:  t = vec;
      default:  t = 16'h0000;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);

  logic [N-1:0] req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic rise;
    logic pend_q;
    assign rise = req_i[i] & ~req_q[i];

    always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= (pend_q & ~clr_i[i]) | rise;
    end
    assign pend_o[i] = pend_q;

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !clr_i[i]) |=> pend_q); // R8
  end

endmodule

// File: rtl/irq_ctrl_port.sv
module irq_ctrl_port #(
  parameter int          CTRL_W    = 4,
  parameter logic [7:0]  CTRL_PORT = 8'hBB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr_i,
  input  logic [7:0]        io_addr_lo_i,
  input  logic [CTRL_W-1:0] io_wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              fwd_o
);

  logic hit;
  logic [CTRL_W-1:0] ctrl_q;

  assign hit   = io_wr_i && (io_addr_lo_i == CTRL_PORT);
  assign fwd_o = io_wr_i && !hit;

  always_ff @(posedge clk) begin
    if (!rst_n)   ctrl_q <= '0;
    else if (hit) ctrl_q <= io_wdata_i;
  end
  assign ctrl_o = ctrl_q;

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr_i && io_addr_lo_i == CTRL_PORT) |=> ctrl_o == $past(io_wdata_i)); // R1

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NM = 4
) (
  input  logic [NM:0]   pend_i,
  input  logic [NM-1:0] mask_i,
  input  logic          iff1_i,
  output logic [NM:0]   grant_o
);

  logic [NM-1:0] qual;
  assign qual = pend_i[NM-1:0] & mask_i & {NM{iff1_i}};

  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    if (pend_i[NM]) begin
      grant_o[NM] = 1'b1;
    end else begin
      for (int i = NM - 1; i >= 0; i--) begin
        if (!found && qual[i]) begin
          grant_o[i] = 1'b1;
          found      = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/irq_restart_arbiter.sv
module irq_restart_arbiter
  import irq_arb_pkg::*;
#(
  parameter logic [7:0] CTRL_PORT = 8'hBB
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_wr_i,
  input  logic [7:0]  io_addr_lo_i,
  input  logic [3:0]  io_wdata_lo_i,
  output logic        io_fwd_wr_o,
  input  logic        nmi_req_i,
  input  logic        rsta_req_i,
  input  logic        rstb_req_i,
  input  logic        rstc_req_i,
  input  logic        vec_req_i,
  input  logic [15:0] ack_vector_i,
  input  logic        ei_i,
  input  logic        di_i,
  input  logic        boundary_i,
  input  logic        push_ack_i,
  output logic        take_o,
  output logic [2:0]  take_src_o,
  output logic [15:0] take_target_o,
  output logic        leave_halt_o,
  output logic        push_req_o,
  output logic        iff1_o,
  output logic        iff2_o
);

  logic [N_SRC-1:0]      req_bus, pend, grant, clr;
  logic [N_MASKABLE-1:0] ctrl;
  logic                  accept, nmi_win;
  irq_src_e              pick_src;

  logic        iff1_q, iff2_q, take_q, halt_q, push_q;
  logic [2:0]  src_q;
  logic [15:0] tgt_q;

  assign req_bus = {nmi_req_i, rsta_req_i, rstb_req_i, rstc_req_i, vec_req_i};

  irq_ctrl_port #(.CTRL_W(N_MASKABLE), .CTRL_PORT(CTRL_PORT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .io_wr_i(io_wr_i), .io_addr_lo_i(io_addr_lo_i),
    .io_wdata_i(io_wdata_lo_i), .ctrl_o(ctrl), .fwd_o(io_fwd_wr_o)
  );

  irq_req_latch #(.N(N_SRC)) u_latch (
    .clk(clk), .rst_n(rst_n), .req_i(req_bus), .clr_i(clr), .pend_o(pend)
  );

  irq_pick #(.NM(N_MASKABLE)) u_pick (
    .pend_i(pend), .mask_i(ctrl), .iff1_i(iff1_q), .grant_o(grant)
  );

  // named decision events
  assign accept   = boundary_i && (|grant) && !push_q;
  assign clr      = grant & {N_SRC{accept}};
  assign nmi_win  = accept && grant[NMI_IDX];
  assign pick_src = grant_to_src(grant);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      halt_q <= 1'b0;
      src_q  <= SRC_NONE;
      tgt_q  <= '0;
    end else begin
      take_q <= accept;
      halt_q <= accept;
      src_q  <= accept ? pick_src : SRC_NONE;
      tgt_q  <= accept ? src_target(pick_src, ack_vector_i) : 16'h0000;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          push_q <= 1'b0;
    else if (accept)     push_q <= 1'b1;
    else if (push_ack_i) push_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iff1_q <= 1'b0;
      iff2_q <= 1'b0;
    end else if (accept) begin
      iff1_q <= 1'b0;
      if (!nmi_win) iff2_q <= 1'b0;
    end else if (di_i) begin
      iff1_q <= 1'b0;
      iff2_q <= 1'b0;
    end else if (ei_i) begin
      iff1_q <= 1'b1;
      iff2_q <= 1'b1;
    end
  end

  assign take_o        = take_q;
  assign leave_halt_o  = halt_q;
  assign take_src_o    = src_q;
  assign take_target_o = tgt_q;
  assign push_req_o    = push_q;
  assign iff1_o        = iff1_q;
  assign iff2_o        = iff2_q;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R4
  AST_MASKABLE_NEEDS_IFF: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant[N_MASKABLE-1:0]) |-> iff1_q); // R3
  AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o); // R9
  AST_TAKE_PUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (push_req_o && leave_halt_o)); // R9
  AST_MASKABLE_CLEARS_IFF: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && take_src_o != SRC_NMI) |-> (!iff1_o && !iff2_o)); // R6
  AST_NMI_KEEPS_IFF2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && take_src_o == SRC_NMI) |-> (!iff1_o && iff2_o == $past(iff2_o))); // R7

endmodule

// File: tb/tb_irq_restart_arbiter.sv
module tb_irq_restart_arbiter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_addr = '0;
  logic [3:0]  io_wdata = '0;
  logic        io_fwd;
  logic [4:0]  req = '0;       // {nmi, a, b, c, vec}
  logic [15:0] ack_vec = '0;
  logic        ei = 1'b0, di = 1'b0, boundary = 1'b0, push_ack = 1'b0;
  logic        take, leave_halt, push_req, iff1, iff2;
  logic [2:0]  take_src;
  logic [15:0] take_tgt;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  typedef struct { logic [2:0] src; logic [15:0] tgt; string tag; } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  irq_restart_arbiter dut (
    .clk(clk), .rst_n(rst_n), .io_wr_i(io_wr), .io_addr_lo_i(io_addr),
    .io_wdata_lo_i(io_wdata), .io_fwd_wr_o(io_fwd),
    .nmi_req_i(req[4]), .rsta_req_i(req[3]), .rstb_req_i(req[2]),
    .rstc_req_i(req[1]), .vec_req_i(req[0]), .ack_vector_i(ack_vec),
    .ei_i(ei), .di_i(di), .boundary_i(boundary), .push_ack_i(push_ack),
    .take_o(take), .take_src_o(take_src), .take_target_o(take_tgt),
    .leave_halt_o(leave_halt), .push_req_o(push_req), .iff1_o(iff1), .iff2_o(iff2)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every accept pulse
  always @(negedge clk) begin
    if (rst_n && take) begin
      if (sb_q.size() == 0) begin
        chk(0, "R3/R4", "unexpected accept, src", {29'd0, take_src}, 32'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(take_src == e.src, e.tag, "source id (R5)", {29'd0, take_src}, {29'd0, e.src});
        chk(take_tgt == e.tgt, e.tag, "target (R5)", {16'd0, take_tgt}, {16'd0, e.tgt});
        chk(leave_halt && push_req, "R9", "halt/push with accept",
            {30'd0, leave_halt, push_req}, 32'd3);
      end
    end
  end

  task automatic expect_take(input logic [2:0] s, input logic [15:0] t, input string tag);
    exp_t e;
    e.src = s; e.tgt = t; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = '0; ei = 0; di = 0; boundary = 0; push_ack = 0; io_wr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_io(input logic [7:0] a, input logic [3:0] d, input bit exp_fwd);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    #1 chk(io_fwd == exp_fwd, "R1", "forward strobe", {31'd0, io_fwd}, {31'd0, exp_fwd});
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic pulse_req(input logic [4:0] m);
    @(negedge clk); req = m;
    @(negedge clk); req = '0;
  endtask

  task automatic do_ei();
    @(negedge clk); ei = 1'b1;
    @(negedge clk); ei = 1'b0;
  endtask

  task automatic do_di();
    @(negedge clk); di = 1'b1;
    @(negedge clk); di = 1'b0;
  endtask

  task automatic strobe(input bit do_ack);
    bit took;
    @(negedge clk); boundary = 1'b1;
    @(negedge clk); boundary = 1'b0;
    #1;
    took = take;
    if (sb_q.size() != 0) begin
      chk(0, sb_q[0].tag, "expected accept missing, src", 32'd0, {29'd0, sb_q[0].src});
      sb_q.delete();
    end
    if (took && do_ack) push_ack = 1'b1;
    @(negedge clk); push_ack = 1'b0;
    if (took) chk(!take, "R9", "accept pulse width", {31'd0, take}, 32'd0);
  endtask

  task automatic chk_iff(input bit e1, input bit e2, input string tag);
    chk(iff1 == e1 && iff2 == e2, tag, "iff1/iff2", {30'd0, iff1, iff2}, {30'd0, e1, e2});
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    do_reset();
    @(negedge clk);
    chk_iff(0, 0, "R10");
    chk(!take && !push_req && !leave_halt && take_src == 3'd0, "R10", "outputs idle",
        {28'd0, take, push_req, leave_halt, 1'b0}, 32'd0);

    // R11: ei / di
    do_ei(); chk_iff(1, 1, "R11");
    do_di(); chk_iff(0, 0, "R11");

    // R7: NMI serviced with IFF1 clear, and keeps IFF2 when set
    pulse_req(5'b10000);
    expect_take(3'd1, 16'h0066, "R7");
    strobe(1);
    chk_iff(0, 0, "R7");
    do_ei();
    pulse_req(5'b10000);
    expect_take(3'd1, 16'h0066, "R7");
    strobe(1);
    chk_iff(0, 1, "R7");

    // R1: port write absorbed, others forwarded
    wr_io(8'hBB, 4'hF, 1'b0);
    wr_io(8'hBC, 4'h5, 1'b1);
    wr_io(8'h00, 4'h0, 1'b1);

    // R4/R5/R6: all four maskable pending, drain in priority order
    ack_vec = 16'h8123;
    pulse_req(5'b01111);
    do_ei(); expect_take(3'd2, 16'h003C, "R4"); strobe(1); chk_iff(0, 0, "R6");
    do_ei(); expect_take(3'd3, 16'h0034, "R4"); strobe(1);
    do_ei(); expect_take(3'd4, 16'h002C, "R4"); strobe(1);
    do_ei(); expect_take(3'd5, 16'h8123, "R5"); strobe(1);
    do_ei(); strobe(1); // R6: nothing left pending
    chk(1, "R6", "drained", 0, 0);

    // R2: mask bits gate each source
    do_reset();
    wr_io(8'hBB, 4'h8, 1'b0);
    pulse_req(5'b00111);
    do_ei(); strobe(1);               // R2: only A enabled, none pending
    chk_iff(1, 1, "R2");
    wr_io(8'hBB, 4'h4, 1'b0);
    expect_take(3'd3, 16'h0034, "R2"); strobe(1);
    wr_io(8'hBB, 4'h3, 1'b0);
    do_ei(); expect_take(3'd4, 16'h002C, "R2"); strobe(1);
    wr_io(8'hBB, 4'h1, 1'b0);
    ack_vec = 16'h4A5B;
    do_ei(); expect_take(3'd5, 16'h4A5B, "R2"); strobe(1);

    // R3: IFF1 clear blocks maskable
    do_reset();
    wr_io(8'hBB, 4'hF, 1'b0);
    pulse_req(5'b01000);
    strobe(1);                         // R3: no accept expected
    do_ei(); expect_take(3'd2, 16'h003C, "R3"); strobe(1);

    // R4/R7: NMI wins over restart A, then A after re-enable
    do_reset();
    wr_io(8'hBB, 4'hF, 1'b0);
    do_ei();
    pulse_req(5'b11000);
    expect_take(3'd1, 16'h0066, "R4"); strobe(1);
    chk_iff(0, 1, "R7");
    strobe(1);                         // R3: IFF1 clear
    do_ei(); expect_take(3'd2, 16'h003C, "R4"); strobe(1);

    // R8: held level does not re-arm
    do_reset();
    wr_io(8'hBB, 4'hF, 1'b0);
    do_ei();
    @(negedge clk); req = 5'b01000;
    expect_take(3'd2, 16'h003C, "R8"); strobe(1);
    do_ei(); strobe(1);                // R8: still held, no new edge
    @(negedge clk); req = '0;
    pulse_req(5'b01000);
    do_ei(); expect_take(3'd2, 16'h003C, "R8"); strobe(1);

    // R9: push request holds and blocks further accepts
    do_reset();
    wr_io(8'hBB, 4'hF, 1'b0);
    do_ei();
    pulse_req(5'b01100);
    expect_take(3'd2, 16'h003C, "R9"); strobe(0);
    repeat (2) @(negedge clk);
    chk(push_req, "R9", "push held until ack", {31'd0, push_req}, 32'd1);
    do_ei(); strobe(0);                // R9: blocked
    @(negedge clk); push_ack = 1'b1;
    @(negedge clk); push_ack = 1'b0;
    chk(!push_req, "R9", "push cleared by ack", {31'd0, push_req}, 32'd0);
    expect_take(3'd3, 16'h0034, "R9"); strobe(1);

    // R10: mask register cleared by reset
    do_reset();
    do_ei();
    pulse_req(5'b01111);
    strobe(1);                         // R10: mask zero, nothing accepted
    chk_iff(1, 1, "R10");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule